// File: doc/BRIEF.md
# Sample-Hold Strobe Time Measurement Unit

This unit counts system-clock cycles relative to rising edges of a sample-and-hold strobe. Two strobe inputs arrive from outside the clock domain. A source-select bit picks the one that is measured. A mode bit picks what is measured:

- **Update-to-strobe mode:** the cycles from the latest filter-update pulse to the latest recognised strobe rising edge.
- **Period mode:** the cycles between two successive recognised rising edges.

Each finished measurement is copied into a result register and raises a sticky done flag.

The filter that makes the update pulse lies outside this unit, and so does the register bus that reads the result. All pins are plain control and status signals. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure. The result simply holds its last value until the next measurement overwrites it.

Top module: `shtime_meas`

## Requirements
- R1: After reset `meas_result` is 0 and `meas_done` is 0, and the unit behaves as if both `mode_sel` and `src_sel` were 0.
- R2: With `src_sel`=0 only `sh_strobe_a` is measured. Edges on `sh_strobe_b` set no done flag and leave the result unchanged.
- R3: With `src_sel`=1 only `sh_strobe_b` is measured. Edges on `sh_strobe_a` set no done flag and leave the result unchanged.
- R4: With `mode_sel`=1 (period mode), every recognised rising edge after the first one since a configuration change stores the number of clock cycles since the previous recognised edge. The first edge only starts the count.
- R5: With `mode_sel`=0 (update-to-strobe mode), a recognised strobe rising edge stores the number of clock cycles since the clock edge that sampled the latest `filt_update` pulse. `filt_update` is sampled directly.
- R6: A strobe level change is recognised at the third rising clock edge that samples the new level. This comes from two synchroniser stages plus one edge-detect register. In mode 0, an update pulse sampled at the same clock edge as a recognised strobe edge stores 0.
- R7: In mode 0, strobe edges seen before any update pulse since the last configuration change are ignored. A later strobe edge with no new update stores the longer time measured from the same update.
- R8: The count saturates at 2^CNT_W-1 and does not wrap. A longer interval stores that maximum.
- R9: `meas_done` rises with the first completed measurement and stays high. A change of `mode_sel` or `src_sel` clears it by the next clock edge and discards any measurement in progress.
- R10: Only rising edges matter. A strobe held high counts as one edge, and falling edges have no effect.
- R11: `meas_result` keeps its value between measurements and across configuration changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sh_strobe_a | input | 1 | Sample-and-hold strobe, source 0 (asynchronous) |
| sh_strobe_b | input | 1 | Sample-and-hold strobe, source 1 (asynchronous) |
| filt_update | input | 1 | Single-cycle filter update pulse, synchronous |
| src_sel | input | 1 | Strobe source select: 0 = `sh_strobe_a`, 1 = `sh_strobe_b` |
| mode_sel | input | 1 | 0 = update-to-strobe, 1 = strobe period |
| meas_result | output | CNT_W | Latest stored measurement in clock cycles |
| meas_done | output | 1 | Sticky flag: a measurement completed since the last configuration change |

## Verification
The embedded assertions check, on every cycle:
- that the detected edge is a single-cycle pulse;
- that the counter stays at its ceiling and holds when idle;
- that the result changes only on a completed measurement;
- that a configuration change always drops the done flag.

Only the bench scenarios can show the measured values themselves. These cover swept periods and update-to-strobe gaps on both sources, the zero result for coincident events, and the growing result for repeated strobes after one update. They also cover saturation and the way the unselected source, early edges and long high levels are ignored.

// File: rtl/shtime_pkg.sv
package shtime_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic {
    MEAS_UPD_TO_SH = 1'b0,
    MEAS_SH_PERIOD = 1'b1
  } meas_mode_e;

  typedef struct packed {
    meas_mode_e mode;
    logic       src;
  } meas_cfg_t;
endpackage

// File: rtl/shtime_sync_edge.sv
module shtime_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

  // R10: a level held high yields a single-cycle edge pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/shtime_counter.sv
module shtime_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         restart,
  input  logic         run,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clear)          count <= '0;
    else if (restart)        count <= W'(1);
    else if (run && count != MAX) count <= count + W'(1);
  end

  // R8: once at the ceiling the count stays there until restarted or cleared
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAX && !clear && !restart) |=> count == MAX);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !restart && !run) |=> $stable(count));
endmodule

// File: rtl/shtime_capture.sv
module shtime_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         end_evt,
  input  logic [W-1:0] end_val,
  output logic [W-1:0] result,
  output logic         done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else if (clear) begin
      done   <= 1'b0;
    end else if (end_evt) begin
      result <= end_val;
      done   <= 1'b1;
    end
  end

  // R11: result only moves on a completed measurement
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !end_evt |=> $stable(result));

  // R9: completion raises the flag
  a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !clear) |=> done);
endmodule

// File: rtl/shtime_meas.sv
module shtime_meas
  import shtime_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_strobe_a,
  input  logic             sh_strobe_b,
  input  logic             filt_update,
  input  logic             src_sel,
  input  logic             mode_sel,
  output logic [CNT_W-1:0] meas_result,
  output logic             meas_done
);
  meas_cfg_t cfg_d, cfg_q;
  logic      cfg_chg;

  assign cfg_d   = '{mode: meas_mode_e'(mode_sel), src: src_sel};
  assign cfg_chg = (cfg_d != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '{mode: MEAS_UPD_TO_SH, src: 1'b0};
    else        cfg_q <= cfg_d;
  end

  // Per-source synchroniser and edge detector; the edges are muxed, not the levels
  logic [NUM_SRC-1:0] raw, rise;
  assign raw = {sh_strobe_b, sh_strobe_a};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    shtime_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .rise (rise[g])
    );
  end

  logic sel_rise;
  assign sel_rise = rise[cfg_q.src];

  // Event decode
  logic             armed_q, start_evt, end_evt, end_zero;
  logic [CNT_W-1:0] count, end_val;

  always_comb begin
    start_evt = 1'b0;
    end_evt   = 1'b0;
    end_zero  = 1'b0;
    if (!cfg_chg) begin
      case (cfg_q.mode)
        MEAS_SH_PERIOD: begin
          start_evt = sel_rise;
          end_evt   = sel_rise && armed_q;
        end
        default: begin
          start_evt = filt_update;
          end_evt   = sel_rise && (armed_q || filt_update);
          end_zero  = filt_update;
        end
      endcase
    end
  end

  assign end_val = end_zero ? '0 : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (cfg_chg)   armed_q <= 1'b0;
    else if (start_evt) armed_q <= 1'b1;
  end

  shtime_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cfg_chg),
    .restart(start_evt),
    .run    (armed_q),
    .count  (count)
  );

  shtime_capture #(.W(CNT_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cfg_chg),
    .end_evt(end_evt),
    .end_val(end_val),
    .result (meas_result),
    .done   (meas_done)
  );

  // R9: any configuration change drops the done flag
  a_r9_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !meas_done);

  // R7: without arming, a mode-0 strobe edge completes nothing
  a_r7_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MEAS_UPD_TO_SH && !armed_q && !filt_update) |=> $stable(meas_result));
endmodule

// File: tb/shtime_meas_test.sv
module shtime_meas_test;
  localparam int W   = 6;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sa = 1'b0, sb = 1'b0, upd = 1'b0, ssel = 1'b0, msel = 1'b0;
  logic [W-1:0] res;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shtime_meas #(.CNT_W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sh_strobe_a(sa), .sh_strobe_b(sb),
    .filt_update(upd), .src_sel(ssel), .mode_sel(msel),
    .meas_result(res), .meas_done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAX) ? MAX : v;
  endfunction

  task automatic drv(input bit s, input logic v);
    if (s) sb = v; else sa = v;
  endtask

  task automatic set_cfg(input bit m, input bit s);
    @(negedge clk); msel = m; ssel = s;
    repeat (2) @(negedge clk);
  endtask

  // one strobe rise, N cycles after the previous rise; result read after recognition
  task automatic m1_step(input int n, input bit s, input bit do_chk, input string tag);
    repeat (n - 3) @(negedge clk);
    drv(s, 1'b1);
    @(negedge clk); drv(s, 1'b0);
    @(negedge clk);
    @(negedge clk);
    if (do_chk) begin
      chk(tag, res, sat(n));
      chk(tag, done, 1);
    end
  endtask

  // update pulse, then strobe raised g cycles later: expected g + 3 (R6 latency)
  task automatic m0_meas(input int g, input bit s, input string tag);
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    repeat (g) @(negedge clk);
    drv(s, 1'b1);
    @(negedge clk); drv(s, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk(tag, res, sat(g + 3));
    chk(tag, done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk("R1 result", res, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 result after release", res, 0);
    chk("R1 done after release", done, 0);

    // R4 period sweep on both sources
    for (int s = 0; s < 2; s++) begin
      set_cfg(1'b1, s[0]);
      chk("R9 done cleared", done, 0);
      m1_step(3, s[0], 1'b0, "R4 arm");
      chk("R4 first edge no done", done, 0);
      for (int n = 3; n <= 40; n++)
        m1_step(n, s[0], 1'b1, s == 0 ? "R4 R2 period a" : "R4 R3 period b");
    end

    // R5 update-to-strobe sweep on both sources
    for (int s = 0; s < 2; s++) begin
      set_cfg(1'b0, s[0]);
      for (int g = 0; g <= 40; g++)
        m0_meas(g, s[0], s == 0 ? "R5 R6 gap a" : "R5 R6 gap b");
    end

    // R6 coincident update and recognised edge
    set_cfg(1'b0, 1'b1);
    set_cfg(1'b0, 1'b0);
    @(negedge clk); sa = 1'b1;
    @(negedge clk); sa = 1'b0;
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    chk("R6 coincident result", res, 0);
    chk("R6 coincident done", done, 1);

    // R7 repeated strobe without new update
    m0_meas(5, 1'b0, "R7 base");
    repeat (7) @(negedge clk);
    sa = 1'b1;
    @(negedge clk); sa = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 growing result", res, 18);

    // R7 edges before any update ignored
    set_cfg(1'b0, 1'b1);
    set_cfg(1'b0, 1'b0);
    chk("R9 done cleared on change", done, 0);
    held = res;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sa = 1'b1;
      repeat (4) @(negedge clk); sa = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R7 unarmed done", done, 0);
    chk("R11 R7 unarmed result", res, held);

    // R2 unselected source b ignored
    set_cfg(1'b1, 1'b0);
    held = res;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sb = 1'b1;
      repeat (2) @(negedge clk); sb = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R2 b ignored done", done, 0);
    chk("R2 b ignored result", res, held);

    // R3 unselected source a ignored
    set_cfg(1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sa = 1'b1;
      repeat (2) @(negedge clk); sa = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R3 a ignored done", done, 0);
    chk("R3 a ignored result", res, held);

    // R10 long high level counts once
    set_cfg(1'b1, 1'b0);
    @(negedge clk); sa = 1'b1;
    repeat (20) @(negedge clk);
    sa = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 held high done", done, 0);
    chk("R10 held high result", res, held);

    // R8 saturation in both modes
    set_cfg(1'b1, 1'b1);
    set_cfg(1'b1, 1'b0);
    m1_step(3, 1'b0, 1'b0, "R8 arm");
    m1_step(100, 1'b0, 1'b1, "R8 period saturate");
    set_cfg(1'b0, 1'b0);
    chk("R11 result kept over change", res, MAX);
    m0_meas(80, 1'b0, "R8 gap saturate");

    // R11 holds while idle
    repeat (30) @(negedge clk);
    chk("R11 idle result", res, MAX);
    chk("R9 done sticky", done, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule